// File: doc/BRIEF.md
# Multi-Window Loss Integrator with Peak Capture

The block takes one loss sample per channel for every strobe of a shared sample-valid signal. For each of its eight channels it keeps three sliding sums: one sample long, a medium window and a long window. It also keeps one running sum over the whole machine cycle. A cycle-start pulse, taken from a timing event, aligns every window to the start of the cycle. Samples from an earlier cycle are never added to, or subtracted from, the sums of a new cycle.

While a cycle runs, the block records the largest value each sliding sum reaches. On the cycle-start pulse it copies those peaks and the whole-cycle total into output registers, which stay unchanged for the whole of the next cycle. It then clears the peaks and the total. The whole-cycle window only grows within a cycle, so its peak is equal to the latched total. That total serves as the ambient-radiation figure for the cycle.

Raw converter values can be fed straight in as samples. Each sliding sum costs one add and one subtract per sample: the sample leaving the window is read from a per-channel history line. The whole-cycle sum saturates instead of wrapping.

Top module: `loss_window_integrator`

## Requirements
- R1: After a synchronous reset, every output (`win_sum`, `win_peak`, `run_total`, `cyc_total`) reads zero.
- R2: Window index 0 is one sample long. After an accepted sample, `win_sum[c][0]` equals that sample on the following clock edge.
- R3: Window index 1 gives the sum of the last `MID_LEN` samples accepted in the current cycle. If fewer samples have arrived since cycle start, it gives the sum of all of them.
- R4: Window index 2 gives the sum of the last `LONG_LEN` samples accepted in the current cycle, or of all of them if fewer have arrived.
- R5: A `cycle_start` pulse restarts every sum from zero. A sample that arrives in the same clock as `cycle_start` is the first sample of the new cycle. Samples from before the pulse are never subtracted from, or counted in, the new sums.
- R6: On `cycle_start`, `win_peak[c][w]` takes the largest value `win_sum[c][w]` held during the ending cycle. It then holds that value until the next `cycle_start`.
- R7: `run_total[c]` is the sum of all samples accepted since the last `cycle_start`. On `cycle_start`, `cyc_total[c]` takes the value of the ending cycle and holds it until the next `cycle_start`.
- R8: `run_total` saturates at 2^`TOT_W`-1 and never wraps. With the defaults, 257 full-scale samples (65535) reach the limit of 16777215.
- R9: In a clock with `smp_valid` low and `cycle_start` low, no sum, peak or total changes.
- R10: Each channel's sums depend only on that channel's samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_start | input | 1 | One-clock pulse that marks the start of a machine cycle |
| smp_valid | input | 1 | A new sample is present on every channel |
| smp_data | input | CH×SAMPLE_W | One unsigned sample per channel |
| win_sum | output | CH×3×SUM_W | Live sliding sums; window index 0 = one sample, 1 = medium, 2 = long |
| win_peak | output | CH×3×SUM_W | Peak of each sliding sum over the last completed cycle |
| run_total | output | CH×TOT_W | Live whole-cycle sum, saturating |
| cyc_total | output | CH×TOT_W | Whole-cycle sum of the last completed cycle |

## Verification
Some properties are checked on every clock by the assertions:
- the one-sample window follows its input;
- a sliding sum never exceeds its peak, and never exceeds window length times full scale;
- idle clocks change nothing;
- the total never falls within a cycle and stays at its limit once saturated;
- the fill count stays bounded;
- the latched registers capture the value held just before the pulse.

Other behaviour needs the bench's scenarios against a model of the sample history:
- the exact contents of the medium and long windows while they fill and slide;
- that samples from the old cycle are never subtracted after a restart;
- the peaks that are reported;
- that the channels stay separate.

// File: rtl/lwi_pkg.sv
package lwi_pkg;

    localparam int LWI_CH       = 8;
    localparam int LWI_SAMPLE_W = 16;
    localparam int LWI_MID_LEN  = 4;
    localparam int LWI_LONG_LEN = 16;
    localparam int LWI_TOT_W    = 24;
    localparam int NSLIDE       = 3;

    typedef enum logic [1:0] {
        WIN_BASE = 2'd0,
        WIN_MED  = 2'd1,
        WIN_LONG = 2'd2
    } win_e;

    // Length in samples of sliding window idx.
    function automatic int win_len(input int idx, input int mid, input int lng);
        case (win_e'(idx))
            WIN_BASE: return 1;
            WIN_MED:  return mid;
            default:  return lng;
        endcase
    endfunction

endpackage

// File: rtl/lwi_history.sv
module lwi_history #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift,
    input  logic [W-1:0]          din,
    output logic [DEPTH-1:0][W-1:0] taps
);
    // taps[k] holds the sample accepted k+1 strobes ago.
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (shift) begin
            taps[0] <= din;
            for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
        end
    end
endmodule

// File: rtl/lwi_slide_win.sv
module lwi_slide_win #(
    parameter int SAMPLE_W = 16,
    parameter int SUM_W    = 21,
    parameter int LEN      = 4,
    parameter int CNT_W    = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] x,
    input  logic [SAMPLE_W-1:0] tap,
    input  logic [CNT_W-1:0]    fill,
    output logic [SUM_W-1:0]    sum,
    output logic [SUM_W-1:0]    peak_hold
);
    localparam longint FULL  = (64'd1 << SAMPLE_W) - 1;
    localparam logic [SUM_W-1:0] BOUND = SUM_W'(FULL * LEN);

    logic [SUM_W-1:0] sum_q, peak_q, base, pbase, drop, sum_n, peak_n;

    always_comb begin
        base   = restart ? '0 : sum_q;
        pbase  = restart ? '0 : peak_q;
        // fill is already zero during restart, so nothing is dropped then
        drop   = (int'(fill) >= LEN) ? SUM_W'(tap) : '0;
        sum_n  = base + SUM_W'(x) - drop;
        peak_n = (sum_n > pbase) ? sum_n : pbase;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q     <= '0;
            peak_q    <= '0;
            peak_hold <= '0;
        end else begin
            if (restart) peak_hold <= peak_q;
            if (valid) begin
                sum_q  <= sum_n;
                peak_q <= peak_n;
            end else if (restart) begin
                sum_q  <= '0;
                peak_q <= '0;
            end
        end
    end

    assign sum = sum_q;

    a_r6_peak_covers_sum: assert property (@(posedge clk) disable iff (rst)
        peak_q >= sum_q);
    a_r6_hold_capture: assert property (@(posedge clk) disable iff (rst)
        restart |=> peak_hold == $past(peak_q));
    a_r4_window_bound: assert property (@(posedge clk) disable iff (rst)
        sum_q <= BOUND);
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!valid && !restart) |=> ($stable(sum_q) && $stable(peak_q) && $stable(peak_hold)));
endmodule

// File: rtl/lwi_cycle_total.sv
module lwi_cycle_total #(
    parameter int SAMPLE_W = 16,
    parameter int TOT_W    = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] x,
    output logic [TOT_W-1:0]    total,
    output logic [TOT_W-1:0]    total_hold
);
    localparam logic [TOT_W-1:0] TMAX = '1;

    logic [TOT_W-1:0] tot_q, base;
    logic [TOT_W:0]   wide;

    always_comb begin
        base = restart ? '0 : tot_q;
        wide = {1'b0, base} + (TOT_W+1)'(x);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tot_q      <= '0;
            total_hold <= '0;
        end else begin
            if (restart) total_hold <= tot_q;
            if (valid)        tot_q <= wide[TOT_W] ? TMAX : wide[TOT_W-1:0];
            else if (restart) tot_q <= '0;
        end
    end

    assign total = tot_q;

    a_r7_no_decrease: assert property (@(posedge clk) disable iff (rst)
        !restart |=> tot_q >= $past(tot_q));
    a_r8_sat_sticky: assert property (@(posedge clk) disable iff (rst)
        (!restart && tot_q == TMAX) |=> tot_q == TMAX);
    a_r7_hold_capture: assert property (@(posedge clk) disable iff (rst)
        restart |=> total_hold == $past(tot_q));
endmodule

// File: rtl/loss_window_integrator.sv
module loss_window_integrator
    import lwi_pkg::*;
#(
    parameter int CH       = LWI_CH,
    parameter int SAMPLE_W = LWI_SAMPLE_W,
    parameter int MID_LEN  = LWI_MID_LEN,
    parameter int LONG_LEN = LWI_LONG_LEN,
    parameter int TOT_W    = LWI_TOT_W,
    localparam int SUM_W   = SAMPLE_W + $clog2(LONG_LEN + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cycle_start,
    input  logic                                 smp_valid,
    input  logic [CH-1:0][SAMPLE_W-1:0]          smp_data,
    output logic [CH-1:0][NSLIDE-1:0][SUM_W-1:0] win_sum,
    output logic [CH-1:0][NSLIDE-1:0][SUM_W-1:0] win_peak,
    output logic [CH-1:0][TOT_W-1:0]             run_total,
    output logic [CH-1:0][TOT_W-1:0]             cyc_total
);
    localparam int CNT_W = $clog2(LONG_LEN + 1);
    localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(LONG_LEN);

    // Samples accepted since cycle start (before the current one), capped.
    logic [CNT_W-1:0] fill_q, fill_base;

    assign fill_base = cycle_start ? '0 : fill_q;

    always_ff @(posedge clk) begin
        if (rst)              fill_q <= '0;
        else if (smp_valid)   fill_q <= (fill_base == FILL_MAX) ? fill_base : fill_base + 1'b1;
        else if (cycle_start) fill_q <= '0;
    end

    a_r5_fill_bounded: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FILL_MAX);
    a_r5_fill_restart: assert property (@(posedge clk) disable iff (rst)
        (cycle_start && !smp_valid) |=> fill_q == '0);

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [LONG_LEN-1:0][SAMPLE_W-1:0] taps;

        lwi_history #(.DEPTH(LONG_LEN), .W(SAMPLE_W)) u_hist (
            .clk   (clk),
            .rst   (rst),
            .shift (smp_valid),
            .din   (smp_data[c]),
            .taps  (taps)
        );

        for (genvar w = 0; w < NSLIDE; w++) begin : g_win
            localparam int L = win_len(w, MID_LEN, LONG_LEN);
            lwi_slide_win #(
                .SAMPLE_W (SAMPLE_W),
                .SUM_W    (SUM_W),
                .LEN      (L),
                .CNT_W    (CNT_W)
            ) u_win (
                .clk       (clk),
                .rst       (rst),
                .restart   (cycle_start),
                .valid     (smp_valid),
                .x         (smp_data[c]),
                .tap       (taps[L-1]),
                .fill      (fill_base),
                .sum       (win_sum[c][w]),
                .peak_hold (win_peak[c][w])
            );
        end

        lwi_cycle_total #(.SAMPLE_W(SAMPLE_W), .TOT_W(TOT_W)) u_tot (
            .clk        (clk),
            .rst        (rst),
            .restart    (cycle_start),
            .valid      (smp_valid),
            .x          (smp_data[c]),
            .total      (run_total[c]),
            .total_hold (cyc_total[c])
        );

        a_r2_base_follows: assert property (@(posedge clk) disable iff (rst)
            smp_valid |=> win_sum[c][0] == SUM_W'($past(smp_data[c])));
    end
endmodule

// File: tb/loss_window_integrator_test.sv
`timescale 1ns/1ps
module loss_window_integrator_test;
    localparam int CH = 8, SW = 16, MID = 4, LNG = 16, TW = 24;
    localparam int SUMW = SW + $clog2(LNG + 1);
    localparam longint TMAX = (64'd1 << TW) - 1;

    logic clk = 1'b0, rst = 1'b1, cycle_start = 1'b0, smp_valid = 1'b0;
    logic [CH-1:0][SW-1:0] smp_data = '0;
    logic [CH-1:0][2:0][SUMW-1:0] win_sum, win_peak;
    logic [CH-1:0][TW-1:0] run_total, cyc_total;

    loss_window_integrator uut (
        .clk(clk), .rst(rst), .cycle_start(cycle_start), .smp_valid(smp_valid),
        .smp_data(smp_data), .win_sum(win_sum), .win_peak(win_peak),
        .run_total(run_total), .cyc_total(cyc_total)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    longint hist [CH][$];
    longint m_peak [CH][3], m_hold [CH][3], m_tot [CH], m_tot_hold [CH];

    function automatic int wlen(int w);
        return (w == 0) ? 1 : (w == 1) ? MID : LNG;
    endfunction

    function automatic longint exp_sum(int c, int w);
        longint s = 0;
        int n = hist[c].size();
        for (int k = 0; k < wlen(w) && k < n; k++) s += hist[c][n-1-k];
        return s;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Model of one clock, derived from the requirements.
    task automatic model(bit v, bit s, logic [CH-1:0][SW-1:0] d);
        for (int c = 0; c < CH; c++) begin
            if (s) begin
                for (int w = 0; w < 3; w++) begin
                    m_hold[c][w] = m_peak[c][w];
                    m_peak[c][w] = 0;
                end
                m_tot_hold[c] = m_tot[c];
                m_tot[c] = 0;
                hist[c].delete();
            end
            if (v) begin
                hist[c].push_back(longint'(d[c]));
                m_tot[c] = (m_tot[c] + d[c] > TMAX) ? TMAX : m_tot[c] + d[c];
                for (int w = 0; w < 3; w++)
                    if (exp_sum(c, w) > m_peak[c][w]) m_peak[c][w] = exp_sum(c, w);
            end
        end
    endtask

    // Drive at a falling edge; return at the next falling edge with results settled.
    task automatic step(bit v, bit s, logic [CH-1:0][SW-1:0] d);
        smp_valid = v; cycle_start = s; smp_data = d;
        model(v, s, d);
        @(negedge clk);
        smp_valid = 1'b0; cycle_start = 1'b0;
    endtask

    task automatic compare_all(string tag);
        for (int c = 0; c < CH; c++) begin
            chk({tag, "/R2"}, $sformatf("ch%0d win0", c), longint'(win_sum[c][0]), exp_sum(c, 0));
            chk({tag, "/R3"}, $sformatf("ch%0d win1", c), longint'(win_sum[c][1]), exp_sum(c, 1));
            chk({tag, "/R4"}, $sformatf("ch%0d win2", c), longint'(win_sum[c][2]), exp_sum(c, 2));
            for (int w = 0; w < 3; w++)
                chk({tag, "/R6"}, $sformatf("ch%0d peak%0d", c, w), longint'(win_peak[c][w]), m_hold[c][w]);
            chk({tag, "/R7"}, $sformatf("ch%0d run_total", c), longint'(run_total[c]), m_tot[c]);
            chk({tag, "/R7"}, $sformatf("ch%0d cyc_total", c), longint'(cyc_total[c]), m_tot_hold[c]);
        end
    endtask

    function automatic logic [CH-1:0][SW-1:0] pattern(int seed);
        logic [CH-1:0][SW-1:0] d;
        for (int c = 0; c < CH; c++) d[c] = SW'(((seed * 37 + c * 101 + seed * seed * 7) % 4000) + 1);
        return d;
    endfunction

    task automatic t_reset();
        compare_all("R1");
    endtask

    task automatic t_fill_and_slide();
        step(1'b0, 1'b1, '0);
        compare_all("R5");
        for (int i = 0; i < 24; i++) begin
            step(1'b1, 1'b0, pattern(i));
            compare_all("R3R4");
        end
    endtask

    task automatic t_idle();
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b0, pattern(99 + i));
            compare_all("R9");
        end
        step(1'b1, 1'b0, pattern(50));
        compare_all("R9");
    endtask

    task automatic t_restart_with_sample();
        step(1'b1, 1'b1, pattern(7));
        compare_all("R5");
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 1'b0, pattern(200 + i));
            compare_all("R5");
        end
    endtask

    task automatic t_restart_idle();
        step(1'b0, 1'b1, pattern(3));
        compare_all("R5");
        step(1'b0, 1'b1, '0);
        compare_all("R6");
    endtask

    task automatic t_channels();
        logic [CH-1:0][SW-1:0] d = '0;
        d[3] = 16'd500;
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b0, d);
            compare_all("R10");
        end
        chk("R10", "ch2 run_total", longint'(run_total[2]), 0);
        chk("R10", "ch3 run_total", longint'(run_total[3]), 2500);
    endtask

    task automatic t_saturate();
        logic [CH-1:0][SW-1:0] full;
        for (int c = 0; c < CH; c++) full[c] = '1;
        step(1'b0, 1'b1, '0);
        for (int i = 0; i < 256; i++) step(1'b1, 1'b0, full);
        chk("R8", "ch0 below limit", longint'(run_total[0]), 256 * 65535);
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b0, full);
            chk("R8", "ch0 saturated", longint'(run_total[0]), TMAX);
        end
        compare_all("R8");
        step(1'b0, 1'b1, '0);
        chk("R8", "ch5 cyc_total", longint'(cyc_total[5]), TMAX);
        compare_all("R8");
    endtask

    initial begin
        for (int c = 0; c < CH; c++) begin
            m_tot[c] = 0; m_tot_hold[c] = 0;
            for (int w = 0; w < 3; w++) begin m_peak[c][w] = 0; m_hold[c][w] = 0; end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_and_slide();
        t_idle();
        t_restart_with_sample();
        t_restart_idle();
        t_channels();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule